// File: doc/BRIEF.md
# Host Bridge Control Register File

This block holds the control words of a host-to-PCI bridge behind a narrow CPU port. The CPU presents a byte address, a write enable and a 32-bit write word; the block returns the addressed 32-bit word combinationally. Only whole-word accesses are defined: the word number is the byte address with its two low bits dropped, so those two bits never matter. The map holds 28 words, from offset 0x00 up to 0x6C.

Most words are plain storage. The interrupt-enable word at 0x38 is never written directly. Instead, a write to the set alias at 0x30 turns on the written ones, and a write to the clear alias at 0x34 turns them off. Both aliases also keep the last value written to them. The status word at 0x3C also refuses CPU writes. A neighbouring interrupt block reads the edge-select word (0x24), the polarity word (0x2C) and the enable word from dedicated outputs.

Bit 2 of the general-configuration word at 0x04 is a self-reset trigger. A write that moves it from 0 to 1 raises a one-cycle system-reset request.

Top module: `nbctl_regfile`

## Requirements
- R1: After synchronous reset the words read: 0x00=0x00000C40, 0x04=0x00001384 (bits 12, 9, 8, 7 and 2 set), 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000, and every other word in 0x00..0x6C reads 0. The reset request output is 0.
- R2: A write to any plain word stores the full 32-bit value, and a read of that word returns it. The word selected is address bits [7:2], so address bits [1:0] are ignored.
- R3: A write to 0x30 stores the written value at 0x30, which reads it back. It also ORs the value into the enable word at 0x38; the change is visible from the next cycle.
- R4: A write to 0x34 stores the written value at 0x34. It also clears, in the enable word at 0x38, every bit that is 1 in the written value.
- R5: Writes to 0x38 and to 0x3C change nothing. 0x38 keeps its value, and 0x3C reads 0.
- R6: A write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0 stores the value. It also drives the reset request high for exactly the one cycle after the write edge.
- R7: A write to 0x04 with bit 2 already 1, or with written bit 2 equal to 0, raises no reset request.
- R8: Byte offsets 0x70 and above read 0, and writes there change no word.
- R9: The outputs for edge select, polarity and enable always equal the words read at 0x24, 0x2C and 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Word at bus_addr, combinational |
| sys_rst_req | output | 1 | One-cycle self-reset request |
| irq_edge_sel | output | 32 | Edge-select word for the interrupt block |
| irq_pol | output | 32 | Polarity word for the interrupt block |
| irq_en | output | 32 | Interrupt-enable word |

## Verification
A corrupted storage word or enable bit shows up at bus_rdata the same cycle its address is presented. An enable corruption also reaches irq_en at once, with no read needed. A wrong compare of the old configuration bit shows up as a missing or extra sys_rst_req in the single cycle after the write edge, so the request must be sampled exactly there. Decoding mistakes, such as stray strobes or out-of-range aliasing, show up as a neighbouring word changing. This is caught by re-reading words that were untouched on purpose.

// File: rtl/nbctl_pkg.sv
// Shared constants and reset values for the bridge control register file.
// Assumes a fixed 28-word map; word numbers here are byte offset / 4.
package nbctl_pkg;
    localparam int DATA_W      = 32;
    localparam int WORDS       = 28;
    localparam int IDX_GEN     = 1;   // general configuration
    localparam int IDX_EDGE    = 9;   // interrupt edge select
    localparam int IDX_POL     = 11;  // interrupt polarity
    localparam int IDX_ENSET   = 12;  // enable set alias
    localparam int IDX_ENCLR   = 13;  // enable clear alias
    localparam int IDX_EN      = 14;  // enable mirror (read only)
    localparam int IDX_STAT    = 15;  // status (read only)
    localparam int GEN_RST_BIT = 2;

    // Reset value of a word, by word number.
    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7, 8:    return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

    // True when the CPU may store into the word.
    function automatic bit cpu_writable(input int idx);
        return (idx < WORDS) && (idx != IDX_EN) && (idx != IDX_STAT);
    endfunction
endpackage

// File: rtl/nbctl_decode.sv
// Address decoder: turns a byte address and write enable into a word number,
// an in-range flag and one write strobe per storable word.
// Assumes word-only access; the low two address bits are dropped.
module nbctl_decode
    import nbctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic [WORDS-1:0]  wr_strobe
);
    // Word number and range check.
    always_comb begin
        idx = addr[ADDR_W-1:2];
        hit = (idx < IDX_W'(WORDS));
    end

    // One strobe per word; read-only words never get one.
    for (genvar g = 0; g < WORDS; g++) begin : g_strobe
        if (cpu_writable(g)) begin : g_rw
            assign wr_strobe[g] = we && (idx == IDX_W'(g));
        end else begin : g_ro
            assign wr_strobe[g] = 1'b0;
        end
    end
endmodule

// File: rtl/nbctl_word.sv
// One storage word with a parameterised reset value.
// Assumes the write strobe is already qualified by the decoder.
module nbctl_word #(
    parameter int                 DATA_W  = 32,
    parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Load reset value, else capture on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/nbctl_irqen.sv
// Interrupt-enable word changed only through set and clear alias writes.
// Assumes set and clear strobes are never active together (distinct words).
module nbctl_irqen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en
);
    logic [DATA_W-1:0] set_mask, clr_mask;

    // Masks that apply only while the matching alias is written.
    always_comb begin
        set_mask = set_wr ? wdata : '0;
        clr_mask = clr_wr ? wdata : '0;
    end

    // Merge set bits, then drop cleared bits.
    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else        en <= (en | set_mask) & ~clr_mask;
    end

    assert_set_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en & $past(wdata)) == $past(wdata)));
    assert_clr_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((en & $past(wdata)) == '0));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(en));
endmodule

// File: rtl/nbctl_selfrst.sv
// Self-reset request: one-cycle pulse after a 0-to-1 write of the trigger bit.
// Assumes old_bit is the stored bit before the write edge.
module nbctl_selfrst (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_wr,
    input  logic old_bit,
    input  logic new_bit,
    output logic req
);
    // Register the rising-write condition for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= gen_wr && !old_bit && new_bit;
    end

    assert_pulse_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(gen_wr));
    assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_wr && old_bit) |=> !req);
endmodule

// File: rtl/nbctl_regfile.sv
// Top of the bridge control register file: decoder, storage words, the
// alias-driven enable word, the self-reset pulse and the read mux.
// Assumes single-cycle word writes and a combinational read path.
module nbctl_regfile
    import nbctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_req,
    output logic [31:0]       irq_edge_sel,
    output logic [31:0]       irq_pol,
    output logic [31:0]       irq_en
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(WORDS);

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic [WORDS-1:0]  wr_strobe;
    logic [DATA_W-1:0] words [WORDS];
    logic [DATA_W-1:0] en_q;
    logic [SEL_W-1:0]  sel;

    nbctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .we(bus_we), .idx(idx), .hit(hit), .wr_strobe(wr_strobe)
    );

    nbctl_irqen #(.DATA_W(DATA_W)) u_en (
        .clk(clk), .rst_n(rst_n),
        .set_wr(wr_strobe[IDX_ENSET]), .clr_wr(wr_strobe[IDX_ENCLR]),
        .wdata(bus_wdata), .en(en_q)
    );

    nbctl_selfrst u_rst (
        .clk(clk), .rst_n(rst_n), .gen_wr(wr_strobe[IDX_GEN]),
        .old_bit(words[IDX_GEN][GEN_RST_BIT]), .new_bit(bus_wdata[GEN_RST_BIT]),
        .req(sys_rst_req)
    );

    // Storage words, the enable mirror and the constant status word.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        if (g == IDX_EN) begin : g_en
            assign words[g] = en_q;
        end else if (g == IDX_STAT) begin : g_stat
            assign words[g] = '0;
        end else begin : g_store
            nbctl_word #(.DATA_W(DATA_W), .RST_VAL(reset_word(g))) u_w (
                .clk(clk), .rst_n(rst_n), .wr(wr_strobe[g]),
                .wdata(bus_wdata), .q(words[g])
            );
        end
    end

    // Read mux: in-range words, zero beyond the map.
    always_comb begin
        sel       = hit ? idx[SEL_W-1:0] : '0;
        bus_rdata = hit ? words[sel] : '0;
    end

    // Side outputs for the interrupt block.
    always_comb begin
        irq_edge_sel = words[IDX_EDGE];
        irq_pol      = words[IDX_POL];
        irq_en       = en_q;
    end

    assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strobe));
    assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(WORDS * 4)) |-> (bus_rdata == '0));
    assert_oob_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(WORDS * 4)) |-> (wr_strobe == '0));
    assert_ro_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[ADDR_W-1:2] == IDX_W'(IDX_EN)) |=> $stable(irq_en));
endmodule

// File: tb/sim_nbctl_regfile.sv
`timescale 1ns/1ps
module sim_nbctl_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_req;
    logic [31:0] irq_edge_sel, irq_pol, irq_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    nbctl_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_req(sys_rst_req),
        .irq_edge_sel(irq_edge_sel), .irq_pol(irq_pol), .irq_en(irq_en)
    );

    // {write addr, write data, read addr, expected read, requirement number}
    localparam int NV = 14;
    localparam logic [83:0] VEC [NV] = '{
        {8'h08, 32'hDEADBEEF, 8'h08, 32'hDEADBEEF, 4'd2},  // R2
        {8'h6C, 32'h12345678, 8'h6C, 32'h12345678, 4'd2},  // R2
        {8'h41, 32'hA5A5A5A5, 8'h40, 32'hA5A5A5A5, 4'd2},  // R2 low bits ignored
        {8'h30, 32'h000000F0, 8'h38, 32'h000000F0, 4'd3},  // R3
        {8'h30, 32'h00000F00, 8'h38, 32'h00000FF0, 4'd3},  // R3
        {8'h34, 32'h00000330, 8'h38, 32'h00000CC0, 4'd4},  // R4
        {8'h38, 32'hFFFFFFFF, 8'h38, 32'h00000CC0, 4'd5},  // R5
        {8'h34, 32'h00000001, 8'h34, 32'h00000001, 4'd4},  // R4 stored
        {8'h30, 32'h00000003, 8'h30, 32'h00000003, 4'd3},  // R3 stored
        {8'h3C, 32'hFFFFFFFF, 8'h3C, 32'h00000000, 4'd5},  // R5
        {8'h70, 32'h00000055, 8'h70, 32'h00000000, 4'd8},  // R8
        {8'hFC, 32'h00000055, 8'hFC, 32'h00000000, 4'd8},  // R8
        {8'h24, 32'h0000000F, 8'h24, 32'h0000000F, 4'd9},  // R9
        {8'h2C, 32'h00000005, 8'h2C, 32'h00000005, 4'd9}   // R9
    };

    // Expected reset word, written from R1.
    function automatic logic [31:0] r1_value(input int i);
        case (i)
            0:  return 32'h00000C40;
            1:  return 32'h00001384;
            2:  return 32'h2BFF8010;
            3:  return 32'h255E0091;
            4:  return 32'h00006140;
            7:  return 32'h000001FF;
            8:  return 32'h000001FF;
            26: return 32'h00000008;
            27: return 32'h10000000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write, finishing at the negedge just after the write edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", {31'b0, sys_rst_req}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 28; i++) begin
            rd(8'(i * 4), v);
            chk($sformatf("R1 word %0d", i), v, r1_value(i));
        end
        chk("R1 req after reset", {31'b0, sys_rst_req}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][83:76], VEC[k][75:44]);
            rd(VEC[k][43:36], v);
            chk($sformatf("R%0d vector %0d", VEC[k][3:0], k), v, VEC[k][35:4]);
        end

        // R8: out-of-range writes left other words intact.
        rd(8'h6C, v);       chk("R8 0x6C intact", v, 32'h12345678);
        rd(8'h00, v);       chk("R8 0x00 intact", v, 32'h00000C40);
        // R9: side outputs mirror the words.
        @(negedge clk);
        chk("R9 edge out", irq_edge_sel, 32'h0000000F);
        chk("R9 pol out", irq_pol, 32'h00000005);
        chk("R9 en out", irq_en, 32'h00000CC3);

        // R7: bit 2 already set, no request.
        wr(8'h04, 32'h00001384);
        chk("R7 no req, bit already 1", {31'b0, sys_rst_req}, 32'h0);
        wr(8'h04, 32'h00000000);
        chk("R7 no req, bit written 0", {31'b0, sys_rst_req}, 32'h0);
        // R6: 0 -> 1 raises a single-cycle request.
        wr(8'h04, 32'h00000004);
        chk("R6 req high", {31'b0, sys_rst_req}, 32'h1);
        @(negedge clk);
        chk("R6 req one cycle", {31'b0, sys_rst_req}, 32'h0);
        rd(8'h04, v);       chk("R6 stored", v, 32'h00000004);
        wr(8'h04, 32'h00000004);
        chk("R7 no req, repeat write", {31'b0, sys_rst_req}, 32'h0);

        // R1: a second reset restores values.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        rd(8'h38, v);       chk("R1 enable after re-reset", v, 32'h0);
        rd(8'h08, v);       chk("R1 0x08 after re-reset", v, 32'h2BFF8010);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule